// File: doc/BRIEF.md
# Dual-Issue Pairing Controller

This block sits at the decode stage of an in-order pipeline that can issue two instructions per cycle. Each cycle it looks at the two oldest decoded instructions, held in slot 0 (older) and slot 1 (younger). For each one it sees a valid bit, a 3-bit group class, a call flag and a decode-lock length. It returns one issue enable per slot. Instructions that compete for the same execution resource are never issued together. Complex instructions issue alone and then freeze decode for a programmed number of cycles.

The front end owns the slots. When only slot 0 issues, it moves the slot-1 instruction into slot 0 for the next cycle, so program order is kept. Typical lock lengths are 5 for return from exception, 2 for an indirect jump or return, and 16 for a call or a call to a support routine. A lock length of L means decode is held for L cycles, counting the issue cycle.

Group codes: MT=0, EX=1, BR=2, LS=3, FE=4, CO=5. Codes 6 and 7 are treated as CO.

Top module: `dual_issue_pairing`

## Requirements
- R1: While `rst` is high, both issue enables are low. On the cycle after a reset cycle, `decode_stall` is low.
- R2: When `decode_stall` is low and `rst` is low, slot 0 issues exactly when `s0_valid` is high, whatever its class.
- R3: Slot 1 never issues in a cycle in which slot 0 does not issue, even when `s1_valid` is high.
- R4: If either slot holds a CO-class instruction (code 5, 6 or 7), slot 1 does not issue.
- R5: Two instructions of the same class, where that class is EX (1), BR (2), LS (3) or FE (4), never issue together.
- R6: When no other rule forbids it, two valid non-CO instructions of different classes issue together. An MT (0) instruction pairs with any non-CO class, including another MT.
- R7: When a locking instruction issues with lock length L ≥ 2, `decode_stall` is high for exactly the next L−1 cycles, and neither slot issues during them. A locking instruction is a CO-class instruction or one with its call flag set.
- R8: A call in slot 0 (`s0_call`=1) never pairs with slot 1. A call in slot 1 may pair with a non-CO, non-call slot-0 instruction, and its lock length then takes effect.
- R9: A lock length of 0 or 1 causes no stall. The lock length of a non-locking instruction has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_class | input | 3 | Slot 0 group class code |
| s0_call | input | 1 | Slot 0 is a call |
| s0_lock | input | LOCK_W (5) | Slot 0 decode-lock length |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_class | input | 3 | Slot 1 group class code |
| s1_call | input | 1 | Slot 1 is a call |
| s1_lock | input | LOCK_W (5) | Slot 1 decode-lock length |
| issue0 | output | 1 | Slot 0 issues this cycle |
| issue1 | output | 1 | Slot 1 issues this cycle |
| decode_stall | output | 1 | Decode is held by an earlier locking instruction |

## Verification
The issue enables are combinational. They are due in the same cycle as the slot contents, so the bench drives the slots just after a falling edge and samples one time unit later, before the next rising edge. `decode_stall` is registered. It rises on the cycle after a locking issue, stays high for L−1 cycles and falls at the clock edge that ends the last of them. The bench updates its own lock count once per cycle at that same edge, so each stall sample is compared with the count the bench has carried forward from earlier cycles.

// File: rtl/issue_pair_pkg.sv
package issue_pair_pkg;

  typedef enum logic [2:0] {
    GRP_MT = 3'd0,
    GRP_EX = 3'd1,
    GRP_BR = 3'd2,
    GRP_LS = 3'd3,
    GRP_FE = 3'd4,
    GRP_CO = 3'd5
  } grp_e;

  localparam int unsigned GRP_W = 3;

  // Class occupies the whole decode stage on its own (reserved codes included).
  function automatic logic grp_is_solo(input logic [GRP_W-1:0] cls);
    return cls >= GRP_CO;
  endfunction

  // Classes that own one single-instance resource.
  function automatic logic grp_is_exclusive(input logic [GRP_W-1:0] cls);
    return (cls == GRP_EX) || (cls == GRP_BR) || (cls == GRP_LS) || (cls == GRP_FE);
  endfunction

  // Two instructions collide on a shared unit.
  function automatic logic grp_collide(input logic [GRP_W-1:0] a,
                                       input logic [GRP_W-1:0] b);
    return (a == b) && grp_is_exclusive(a);
  endfunction

  // Extra held cycles after the issue cycle for a lock length.
  function automatic logic [7:0] hold_after_issue(input logic [7:0] len);
    return (len > 8'd1) ? (len - 8'd1) : 8'd0;
  endfunction

endpackage

// File: rtl/slot_decode.sv
module slot_decode
  import issue_pair_pkg::*;
#(
  parameter int unsigned LOCK_W = 5
) (
  input  logic              valid,
  input  logic [GRP_W-1:0]  cls,
  input  logic              call,
  input  logic [LOCK_W-1:0] lock_len,
  output logic              present,
  output logic              solo,
  output logic              locking,
  output logic [LOCK_W-1:0] hold
);
  logic [7:0] len_ext;
  logic [7:0] hold_ext;

  always_comb begin
    len_ext  = 8'(lock_len);
    hold_ext = hold_after_issue(len_ext);
    present  = valid;
    solo     = valid && grp_is_solo(cls);
    locking  = valid && (grp_is_solo(cls) || call);
    hold     = locking ? hold_ext[LOCK_W-1:0] : '0;
  end
endmodule

// File: rtl/pair_rules.sv
module pair_rules
  import issue_pair_pkg::*;
(
  input  logic             rst,
  input  logic             busy,
  input  logic             p0,
  input  logic             p1,
  input  logic             solo0,
  input  logic             solo1,
  input  logic             call0,
  input  logic [GRP_W-1:0] cls0,
  input  logic [GRP_W-1:0] cls1,
  output logic             unit_clash,
  output logic             solo_block,
  output logic             call_block,
  output logic             go0,
  output logic             go1
);
  always_comb begin
    unit_clash = grp_collide(cls0, cls1);
    solo_block = solo0 || solo1;
    call_block = call0;
    go0        = !rst && !busy && p0;
    go1        = go0 && p1 && !unit_clash && !solo_block && !call_block;
  end
endmodule

// File: rtl/lock_counter.sv
module lock_counter #(
  parameter int unsigned LOCK_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LOCK_W-1:0] load_val,
  output logic              busy,
  output logic [LOCK_W-1:0] remaining
);
  logic [LOCK_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    else if (load)         cnt_q <= load_val;
  end

  assign busy      = (cnt_q != '0);
  assign remaining = cnt_q;
endmodule

// File: rtl/dual_issue_pairing.sv
module dual_issue_pairing
  import issue_pair_pkg::*;
#(
  parameter int unsigned LOCK_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s0_valid,
  input  logic [2:0]        s0_class,
  input  logic              s0_call,
  input  logic [LOCK_W-1:0] s0_lock,
  input  logic              s1_valid,
  input  logic [2:0]        s1_class,
  input  logic              s1_call,
  input  logic [LOCK_W-1:0] s1_lock,
  output logic              issue0,
  output logic              issue1,
  output logic              decode_stall
);
  localparam int unsigned NSLOT = 2;

  logic              v_a   [NSLOT];
  logic [GRP_W-1:0]  c_a   [NSLOT];
  logic              k_a   [NSLOT];
  logic [LOCK_W-1:0] l_a   [NSLOT];
  logic              pres  [NSLOT];
  logic              solo  [NSLOT];
  logic              lockg [NSLOT];
  logic [LOCK_W-1:0] hold  [NSLOT];

  assign v_a[0] = s0_valid; assign c_a[0] = s0_class;
  assign k_a[0] = s0_call;  assign l_a[0] = s0_lock;
  assign v_a[1] = s1_valid; assign c_a[1] = s1_class;
  assign k_a[1] = s1_call;  assign l_a[1] = s1_lock;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    slot_decode #(.LOCK_W(LOCK_W)) u_dec (
      .valid(v_a[g]), .cls(c_a[g]), .call(k_a[g]), .lock_len(l_a[g]),
      .present(pres[g]), .solo(solo[g]), .locking(lockg[g]), .hold(hold[g])
    );
  end

  // Named internal events for the checker
  logic              unit_clash, solo_block, call_block;
  logic              busy;
  logic [LOCK_W-1:0] remaining;
  logic              lock_load;
  logic [LOCK_W-1:0] lock_val;

  pair_rules u_rules (
    .rst(rst), .busy(busy), .p0(pres[0]), .p1(pres[1]),
    .solo0(solo[0]), .solo1(solo[1]), .call0(s0_call && s0_valid),
    .cls0(c_a[0]), .cls1(c_a[1]),
    .unit_clash(unit_clash), .solo_block(solo_block), .call_block(call_block),
    .go0(issue0), .go1(issue1)
  );

  always_comb begin
    lock_val = '0;
    if (issue0 && lockg[0])      lock_val = hold[0];
    else if (issue1 && lockg[1]) lock_val = hold[1];
    lock_load = (lock_val != '0);
  end

  lock_counter #(.LOCK_W(LOCK_W)) u_lock (
    .clk(clk), .rst(rst), .load(lock_load), .load_val(lock_val),
    .busy(busy), .remaining(remaining)
  );

  assign decode_stall = busy;
endmodule

// File: rtl/dual_issue_pairing_chk.sv
module dual_issue_pairing_chk #(
  parameter int unsigned LOCK_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              s0_valid,
  input logic [2:0]        s0_class,
  input logic              s0_call,
  input logic              s1_valid,
  input logic [2:0]        s1_class,
  input logic              issue0,
  input logic              issue1,
  input logic              decode_stall,
  input logic              lock_load,
  input logic [LOCK_W-1:0] lock_val,
  input logic [LOCK_W-1:0] remaining
);
  always_comb begin
    if (rst) assert_reset_quiet_R1: assert (!issue0 && !issue1);
  end

  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> !decode_stall);

  assert_slot0_issue_R2: assert property (@(posedge clk) disable iff (rst)
    (!decode_stall && s0_valid) |-> issue0);

  assert_in_order_R3: assert property (@(posedge clk) disable iff (rst)
    issue1 |-> issue0);

  assert_solo_alone_R4: assert property (@(posedge clk) disable iff (rst)
    (s0_class >= 3'd5 || s1_class >= 3'd5) |-> !issue1);

  assert_no_shared_unit_R5: assert property (@(posedge clk) disable iff (rst)
    (issue1 && s0_class == s1_class) |-> (s0_class == 3'd0));

  assert_no_issue_in_stall_R7: assert property (@(posedge clk) disable iff (rst)
    decode_stall |-> (!issue0 && !issue1));

  assert_stall_starts_R7: assert property (@(posedge clk) disable iff (rst)
    lock_load |=> (decode_stall && remaining == $past(lock_val)));

  assert_stall_counts_R7: assert property (@(posedge clk) disable iff (rst)
    (remaining > 1) |=> (remaining == $past(remaining) - 1'b1));

  assert_stall_ends_R7: assert property (@(posedge clk) disable iff (rst)
    (remaining == 1) |=> !decode_stall);

  assert_call_first_R8: assert property (@(posedge clk) disable iff (rst)
    (s0_valid && s0_call) |-> !issue1);

  assert_pair_when_free_R6: assert property (@(posedge clk) disable iff (rst)
    (issue0 && s1_valid && !s0_call && s0_class < 3'd5 && s1_class < 3'd5 &&
     s0_class != s1_class) |-> issue1);
endmodule

bind dual_issue_pairing dual_issue_pairing_chk #(.LOCK_W(LOCK_W)) u_chk (
  .clk(clk), .rst(rst), .s0_valid(s0_valid), .s0_class(s0_class), .s0_call(s0_call),
  .s1_valid(s1_valid), .s1_class(s1_class), .issue0(issue0), .issue1(issue1),
  .decode_stall(decode_stall), .lock_load(lock_load), .lock_val(lock_val),
  .remaining(remaining)
);

// File: tb/tb_dual_issue_pairing.sv
module tb_dual_issue_pairing;
  localparam int LW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic s0_valid, s0_call, s1_valid, s1_call;
  logic [2:0] s0_class, s1_class;
  logic [LW-1:0] s0_lock, s1_lock;
  logic issue0, issue1, decode_stall;

  dual_issue_pairing #(.LOCK_W(LW)) dut (.*);

  int checks = 0;
  int errors = 0;
  int m_cnt  = 0;   // bench model of remaining held cycles

  function automatic bit b_solo(input logic [2:0] c);
    return c == 3'd5 || c == 3'd6 || c == 3'd7;
  endfunction

  function automatic bit b_can_pair(input logic [2:0] a, input logic [2:0] b, input bit call_a);
    if (b_solo(a) || b_solo(b) || call_a) return 0;
    if (a == 3'd0 || b == 3'd0) return 1;
    return a != b;
  endfunction

  function automatic string why(input bit v0, input logic [2:0] c0, input bit k0,
                                input logic [2:0] c1);
    if (m_cnt != 0) return "R7";
    if (!v0) return "R3";
    if (b_solo(c0) || b_solo(c1)) return "R4";
    if (k0) return "R8";
    if (c0 == c1 && c0 != 3'd0) return "R5";
    return "R6";
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v0, input logic [2:0] c0, input bit k0, input int l0,
                      input bit v1, input logic [2:0] c1, input bit k1, input int l1,
                      input string tag);
    bit e0, e1;
    int hold;
    s0_valid = v0; s0_class = c0; s0_call = k0; s0_lock = LW'(l0);
    s1_valid = v1; s1_class = c1; s1_call = k1; s1_lock = LW'(l1);
    #1;
    e0 = (m_cnt == 0) && v0;
    e1 = e0 && v1 && b_can_pair(c0, c1, k0);
    chk((tag != "") ? tag : "R2", "issue0", int'(issue0), int'(e0));
    chk((tag != "") ? tag : why(v0, c0, k0, c1), "issue1", int'(issue1), int'(e1));
    chk("R7", "decode_stall", int'(decode_stall), int'(m_cnt != 0));
    hold = 0;
    if (e0 && (b_solo(c0) || k0) && l0 > 1)      hold = l0 - 1;
    else if (e1 && (b_solo(c1) || k1) && l1 > 1) hold = l1 - 1;
    if (m_cnt != 0) m_cnt = m_cnt - 1;
    else            m_cnt = hold;
    @(negedge clk);
  endtask

  task automatic idle_until_free(input string tag);
    while (m_cnt != 0) step(1, 3'd0, 0, 0, 1, 3'd1, 0, 0, tag);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    rst = 1'b1;
    s0_valid = 0; s0_class = 0; s0_call = 0; s0_lock = 0;
    s1_valid = 0; s1_class = 0; s1_call = 0; s1_lock = 0;
    @(negedge clk);
    // R1: enables low during reset even with valid slots
    s0_valid = 1; s1_valid = 1; #1;
    chk("R1", "issue0 in reset", int'(issue0), 0);
    chk("R1", "issue1 in reset", int'(issue1), 0);
    @(negedge clk);
    chk("R1", "stall after reset", int'(decode_stall), 0);
    rst = 1'b0;

    // Directed pairing cases
    step(1, 3'd0, 0, 0, 1, 3'd1, 0, 0, "R6");   // MT + EX
    step(1, 3'd0, 0, 0, 1, 3'd0, 0, 0, "R6");   // MT + MT
    step(1, 3'd3, 0, 0, 1, 3'd4, 0, 0, "R6");   // LS + FE
    step(1, 3'd1, 0, 0, 1, 3'd1, 0, 0, "R5");   // EX + EX
    step(1, 3'd1, 0, 0, 0, 3'd0, 0, 0, "R2");   // older slot alone, moved forward
    step(1, 3'd2, 0, 0, 1, 3'd2, 0, 0, "R5");   // BR + BR
    step(1, 3'd2, 0, 0, 0, 3'd0, 0, 0, "R5");   // younger BR now in slot 0
    step(0, 3'd0, 0, 0, 1, 3'd0, 0, 0, "R3");   // slot 1 without slot 0
    step(1, 3'd0, 0, 0, 1, 3'd5, 0, 1, "R4");   // CO in slot 1
    step(1, 3'd7, 0, 1, 1, 3'd0, 0, 0, "R4");   // reserved code acts as CO
    // R9: lock lengths 0 and 1, and lock of non-locking instr
    step(1, 3'd5, 0, 0, 0, 3'd0, 0, 0, "R9");
    step(1, 3'd5, 0, 1, 0, 3'd0, 0, 0, "R9");
    step(1, 3'd1, 0, 9, 1, 3'd3, 0, 9, "R9");
    step(1, 3'd0, 0, 0, 0, 3'd0, 0, 0, "R9");
    // R7: exception return, 5-cycle hold
    step(1, 3'd5, 0, 5, 1, 3'd0, 0, 0, "R7");
    idle_until_free("R7");
    step(1, 3'd0, 0, 0, 0, 3'd0, 0, 0, "R7");
    // R8: call in slot 0 refuses pairing, call in slot 1 pairs and locks 16
    step(1, 3'd2, 1, 2, 1, 3'd0, 0, 0, "R8");
    idle_until_free("R8");
    step(1, 3'd0, 0, 0, 1, 3'd2, 1, 16, "R8");
    idle_until_free("R8");
    step(1, 3'd1, 0, 0, 1, 3'd0, 0, 0, "R8");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      bit v0, v1, k0, k1;
      logic [2:0] c0, c1;
      int l0, l1;
      v0 = ($urandom % 8) != 0;
      v1 = ($urandom % 4) != 0;
      c0 = 3'($urandom % 8);
      c1 = 3'($urandom % 8);
      if (($urandom % 4) != 0 && c0 >= 3'd5) c0 = 3'($urandom % 5);
      if (($urandom % 4) != 0 && c1 >= 3'd5) c1 = 3'($urandom % 5);
      k0 = ($urandom % 10) == 0;
      k1 = ($urandom % 10) == 0;
      l0 = (($urandom % 8) == 0) ? 16 : int'($urandom % 6);
      l1 = (($urandom % 8) == 0) ? 16 : int'($urandom % 6);
      step(v0, c0, k0, l0, v1, c1, k1, l1, "");
    end

    // Reset in the middle of a hold
    step(1, 3'd5, 0, 16, 0, 3'd0, 0, 0, "R7");
    step(1, 3'd0, 0, 0, 0, 3'd0, 0, 0, "R7");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 0;
    chk("R1", "stall cleared by reset", int'(decode_stall), 0);
    step(1, 3'd0, 0, 0, 1, 3'd4, 0, 0, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule